// File: doc/BRIEF.md
# External Interrupt Pending Flag Controller

This block holds the pending state of a single external interrupt line. It watches an already synchronized pin. A two-bit sense-mode input chooses what counts as a trigger: a low level, any transition, a falling transition or a rising transition. In the three transition modes a qualifying transition latches a pending flag. The flag is cleared in two ways: the core pulses a service acknowledge when it enters the handler, or software writes a one to the flag's bit position. In the low-level mode nothing is latched. The request simply follows the pin while it is low, and the flag reads as zero.

An interrupt request goes to the core only while both the global interrupt enable and the line's own enable are set. The flag appears at bit 6 of an 8-bit readback byte, and every other bit of that byte reads as zero.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal that is sampled on each rising clock edge. The readback byte and the request line are combinational views of the registered state and the current inputs.

Top module: `extint_flag_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, the readback byte is 0x00 and the request line is low.
- R2: Sense-mode encodings are 2'b11 rising, 2'b10 falling and 2'b01 either transition. A qualifying transition between the previous sample and the current sample sets the flag, and the flag is visible on the cycle after the transition. The first sample after reset is never treated as a transition.
- R3: In the transition modes the request equals flag AND local enable AND global enable, within the same cycle.
- R4: A service acknowledge pulse clears the flag, and the flag reads zero on the next cycle.
- R5: A register write with bit 6 of the write data set to one clears the flag. A write with bit 6 at zero leaves the flag unchanged, whatever the other bits hold.
- R6: When a qualifying transition and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R7: Sense-mode 2'b00 selects low-level mode. In this mode the flag reads zero from the same cycle on and is held cleared. The request equals (pin low) AND local enable AND global enable, with no latching.
- R8: Bits 7 and 5..0 of the readback byte always read zero.
- R9: A transition of the direction the current mode does not select leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_sync | input | 1 | Synchronized external interrupt pin |
| sense_mode | input | 2 | 00 low level, 01 any edge, 10 falling, 11 rising |
| glob_en | input | 1 | Global interrupt enable |
| line_en | input | 1 | Enable for this interrupt line |
| svc_ack | input | 1 | Pulse when the handler is entered; clears the flag |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_data | input | 8 | Write data; a one at bit 6 clears the flag |
| flag_rd | output | 8 | Readback byte: flag at bit 6, other bits zero |
| irq | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that pin_sync is already free of metastability and changes only between clock edges. They also assume that svc_ack is a single-cycle pulse that the core produces after it has seen the request, although the flag logic stays correct even when acknowledges arrive unprompted. The stimulus drives every input just after the falling clock edge, so each value is stable across the next rising edge. Random traffic toggles the pin often, changes the sense mode only now and then, and issues sparse acknowledges and writes, so that sets and clears overlap in some cycles. Directed sequences cover the first sample after reset, rejection of the wrong transition direction, a write of zero and a coinciding set and clear.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned FLAG_POS = 6;
endpackage

// File: rtl/extint_edge_det.sv
module extint_edge_det
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);
  logic prev_q;
  logic primed_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin;
      primed_q <= 1'b1;
    end
  end

  assign rise = primed_q &  pin & ~prev_q;
  assign fall = primed_q & ~pin &  prev_q;

  always_comb begin
    unique case (sense_e'(mode))
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // R2
  no_hit_unprimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> !hit);
endmodule

// File: rtl/extint_flag_reg.sv
module extint_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic level_mode,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (level_mode) flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (clr)        flag_q <= 1'b0;
  end

  // R2
  set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !level_mode |=> flag_q);
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag_q);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !clr && !level_mode |=> $stable(flag_q));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && clr && !level_mode |=> flag_q);
  // R7
  level_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |=> !flag_q);
endmodule

// File: rtl/extint_req.sv
module extint_req #(
  parameter bit ACTIVE_LEVEL = 1'b0
) (
  input  logic flag,
  input  logic pin,
  input  logic level_mode,
  input  logic glob_en,
  input  logic line_en,
  output logic irq
);
  logic source;

  assign source = level_mode ? (pin == ACTIVE_LEVEL) : flag;
  assign irq    = source & glob_en & line_en;
endmodule

// File: rtl/extint_flag_ctrl.sv
module extint_flag_ctrl
  import extint_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_sync,
  input  logic [1:0]          sense_mode,
  input  logic                glob_en,
  input  logic                line_en,
  input  logic                svc_ack,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    flag_rd,
  output logic                irq
);
  logic hit;
  logic level_mode;
  logic sw_clr;
  logic flag_q;
  logic unused_ok;

  assign level_mode = (sense_e'(sense_mode) == SENSE_LOW);
  assign sw_clr     = wr_en & wr_data[FLAG_POS];
  assign unused_ok  = &{1'b0, wr_data};

  extint_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (pin_sync),
    .mode  (sense_mode),
    .hit   (hit)
  );

  extint_flag_reg u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .level_mode (level_mode),
    .clr        (svc_ack | sw_clr),
    .flag_q     (flag_q)
  );

  extint_req #(.ACTIVE_LEVEL(1'b0)) u_req (
    .flag       (flag_q),
    .pin        (pin_sync),
    .level_mode (level_mode),
    .glob_en    (glob_en),
    .line_en    (line_en),
    .irq        (irq)
  );

  always_comb begin
    flag_rd           = '0;
    flag_rd[FLAG_POS] = flag_q & ~level_mode;
  end

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glob_en && line_en);
  // R7
  level_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |-> flag_rd == '0);
endmodule

// File: tb/extint_flag_ctrl_bench.sv
module extint_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_sync = 1'b1;
  logic [1:0] sense_mode = 2'b11;
  logic       glob_en = 1'b0, line_en = 1'b0, svc_ack = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] flag_rd;
  logic       irq;

  int tests = 0, fails = 0;
  bit m_prev = 1'b0, m_primed = 1'b0, m_flag = 1'b0;

  extint_flag_ctrl u_extint_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .sense_mode(sense_mode),
    .glob_en(glob_en), .line_en(line_en), .svc_ack(svc_ack), .wr_en(wr_en),
    .wr_data(wr_data), .flag_rd(flag_rd), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic bit qual(input logic [1:0] md, input bit prv, input bit cur, input bit primed);
    if (!primed) return 1'b0;
    case (md)
      2'b01:   return prv != cur;
      2'b10:   return prv & ~cur;
      2'b11:   return ~prv & cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd();
    return {1'b0, m_flag & (sense_mode != 2'b00), 6'b0};
  endfunction

  function automatic bit exp_irq();
    bit src = (sense_mode == 2'b00) ? ~pin_sync : m_flag;
    return src & glob_en & line_en;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_update();
    bit lvl = (sense_mode == 2'b00);
    bit e = qual(sense_mode, m_prev, pin_sync, m_primed);
    if (lvl) m_flag = 1'b0;
    else if (e) m_flag = 1'b1;
    else if (svc_ack || (wr_en && wr_data[6])) m_flag = 1'b0;
    m_prev = pin_sync;
    m_primed = 1'b1;
  endtask

  task automatic step(input bit p, input logic [1:0] md, input bit g, input bit l,
                      input bit a, input bit w, input logic [7:0] d);
    @(negedge clk);
    pin_sync = p; sense_mode = md; glob_en = g; line_en = l;
    svc_ack = a; wr_en = w; wr_data = d;
    #2;
    check("R8", flag_rd, exp_rd());
    check("R3", {7'b0, irq}, {7'b0, exp_irq()});
    @(posedge clk);
    #1 model_update();
  endtask

  task automatic expect_flag(input string req, input bit f);
    #1 check(req, flag_rd, {1'b0, f, 6'b0});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #35;
    check("R1", flag_rd, 8'h00);
    check("R1", {7'b0, irq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    #2 check("R1", flag_rd, 8'h00);
    // R2: pin held high from reset is no transition
    step(1, 2'b11, 1, 1, 0, 0, 8'h00); expect_flag("R2", 0);
    // R9: falling while rising selected
    step(0, 2'b11, 1, 1, 0, 0, 8'h00); expect_flag("R9", 0);
    step(1, 2'b11, 1, 1, 0, 0, 8'h00); expect_flag("R2", 1);
    #1 check("R3", {7'b0, irq}, 8'h01);
    // R5: writes with bit 6 low keep the flag
    step(1, 2'b11, 1, 1, 0, 1, 8'h00); expect_flag("R5", 1);
    step(1, 2'b11, 1, 1, 0, 1, 8'hBF); expect_flag("R5", 1);
    step(1, 2'b11, 0, 1, 0, 0, 8'h00);
    #1 check("R3", {7'b0, irq}, 8'h00);
    step(1, 2'b11, 1, 1, 0, 1, 8'h40); expect_flag("R5", 0);
    // R4: service acknowledge
    step(0, 2'b10, 1, 1, 0, 0, 8'h00); expect_flag("R2", 1);
    step(0, 2'b10, 1, 1, 1, 0, 8'h00); expect_flag("R4", 0);
    // R6: transition and clear in the same cycle
    step(1, 2'b01, 1, 1, 1, 1, 8'h40); expect_flag("R6", 1);
    // R7: level mode masks flag at once and follows pin
    step(0, 2'b00, 1, 1, 0, 0, 8'h00);
    check("R7", flag_rd, 8'h00);
    check("R7", {7'b0, irq}, 8'h01);
    step(1, 2'b00, 1, 1, 0, 0, 8'h00);
    check("R7", {7'b0, irq}, 8'h00);
    step(1, 2'b11, 1, 1, 0, 0, 8'h00); expect_flag("R7", 0);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] md = sense_mode;
      if ($urandom_range(15) == 0) md = 2'($urandom);
      step(($urandom_range(2) == 0) ? ~pin_sync : pin_sync, md,
           $urandom_range(3) != 0, $urandom_range(3) != 0,
           $urandom_range(7) == 0, $urandom_range(7) == 0, 8'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule